// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the hardware half of taking an interrupt on a small real-time core. It watches a set of request lines, each with an 8-bit priority. It picks the most urgent pending request, which must also be more urgent than the code now running. It then pushes a fixed eight-word context frame onto the active stack through a plain word-write port. After the frame it reads the handler address from a vector table, switches to handler mode and hands a new program counter and link value to the core. The interrupted context comes in as a snapshot of eight words.

Two stack pointers are kept inside the block. The main pointer serves handlers. The process pointer may serve task code in thread mode. A frame always goes onto the stack that was active when the request was accepted, and after entry the main stack is in use. Nested entries follow when a more urgent request arrives during a handler. Every entry takes the same number of cycles, whatever the data or the line.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block is in thread mode, `msp_out` and `psp_out` hold their reset parameters, `run_prio` reads 256 (nothing running), and `mem_we`, `vec_re` and `done` are low.
- R2: Among lines that are pending or requesting in the current cycle, the line with the numerically lowest priority wins, and on a tie the lowest line index wins. `active_line` names the accepted line once `done` is high.
- R3: A request is accepted only if its priority is strictly below `run_prio`. An equal or larger value stays pending and causes no write, no vector read and no `done`.
- R4: An entry makes exactly eight writes on eight consecutive cycles. The addresses descend in steps of 4, starting at the old stack pointer minus 4. Word k of `frame_in` (bits 32k+31..32k; slots 0..7 = r0, r1, r2, r3, r12, LR, return PC, status) ends up at new pointer + 4k, so the status word is written first.
- R5: The frame goes to the process stack only when the block is in thread mode and `thread_psp` is high at acceptance. Otherwise it goes to the main stack, and `thread_psp` has no effect in handler mode. Only the pointer that was used drops by 32.
- R6: One cycle after the last write, `vec_re` is high for one cycle with `vec_addr` = VEC_BASE + 4*(16 + line). `vec_rdata` is sampled one cycle later, and `pc_out` becomes that word with bit 0 cleared.
- R7: `lr_out` becomes 0xFFFFFFF1 for an entry from handler mode, 0xFFFFFFF9 for an entry from thread mode on the main stack, and 0xFFFFFFFD for an entry from thread mode on the process stack.
- R8: When `done` is high, `handler_mode` is 1 and `run_prio` holds the accepted priority.
- R9: `done` is a one-cycle pulse exactly 12 cycles after the first frame write, and `entry_lat` reads 12 at that point, on every entry.
- R10: A request raised in the cycle `done` is high is judged in that same cycle. If it can preempt, its first frame write comes in the very next cycle.
- R11: A request pulse that arrives while an entry is under way is latched, and it is taken after that entry completes if it can preempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | N_IRQ | Request pulses or levels, one per line |
| irq_prio | input | N_IRQ*PW | Priority per line, line i at bits PW*i upward |
| thread_psp | input | 1 | Thread code is using the process stack |
| frame_in | input | 256 | Snapshot of the eight context words |
| mem_we | output | 1 | Frame word write strobe |
| mem_addr | output | AW | Frame word byte address |
| mem_wdata | output | 32 | Frame word data |
| vec_re | output | 1 | Vector table read strobe |
| vec_addr | output | AW | Vector entry byte address |
| vec_rdata | input | 32 | Vector word, valid the cycle after `vec_re` |
| done | output | 1 | Entry complete pulse |
| entry_lat | output | 8 | Measured cycles of the last entry |
| handler_mode | output | 1 | 1 = handler mode, 0 = thread mode |
| active_line | output | IW | Line of the last accepted entry |
| run_prio | output | PW+1 | Running priority, 256 when idle |
| msp_out | output | AW | Main stack pointer |
| psp_out | output | AW | Process stack pointer |
| pc_out | output | 32 | Handler start address |
| lr_out | output | 32 | Return-code link value |

## Verification
The delicate overlap is completion meeting a new decision. In one cycle `done` can announce the end of an entry while the arbiter weighs a fresh request against the running priority just raised by that entry. The bench raises a more urgent line exactly in the `done` cycle, and also pulses one mid-entry. It then checks that the next frame write appears the following cycle, that it lands on the main stack with the handler return code, and that the first entry's results are left intact. Random two-line contests with a follow-up nested entry are checked against a bench model of priority, stack choice and frame layout.

// File: rtl/irq_entry_pkg.sv
// Package: shared constants and helpers for the interrupt entry sequencer.
// Assumes 32-bit context words and an eight-word frame.
package irq_entry_pkg;
    localparam int WORD_W      = 32;
    localparam int FRAME_WORDS = 8;
    localparam int ENTRY_LEN   = 12;
    localparam int EXC_OFS     = 16;
    localparam int LAT_W       = 8;

    localparam logic [WORD_W-1:0] RET_HND     = 32'hFFFF_FFF1;
    localparam logic [WORD_W-1:0] RET_THR_MSP = 32'hFFFF_FFF9;
    localparam logic [WORD_W-1:0] RET_THR_PSP = 32'hFFFF_FFFD;

    typedef enum logic [0:0] {SQ_IDLE, SQ_BUSY} seq_state_t;

    // Return code recording the interrupted mode and stack.
    function automatic logic [WORD_W-1:0] ret_code(input logic from_hnd, input logic used_psp);
        if (from_hnd) return RET_HND;
        return used_psp ? RET_THR_PSP : RET_THR_MSP;
    endfunction
endpackage

// File: rtl/irq_prio_pick.sv
// Module: picks the most urgent candidate line.
// Lower priority value wins; ties go to the lower index. Purely combinational.
module irq_prio_pick #(
    parameter int N_IRQ = 8,
    parameter int PW    = 8,
    parameter int IW    = 3
) (
    input  logic [N_IRQ-1:0]    cand,
    input  logic [N_IRQ*PW-1:0] prio,
    output logic                hit,
    output logic [IW-1:0]       idx,
    output logic [PW-1:0]       best
);
    // Linear scan; strict compare keeps the lowest index on ties.
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        best = '1;
        for (int i = 0; i < N_IRQ; i++) begin
            if (cand[i] && (!hit || prio[i*PW +: PW] < best)) begin
                hit  = 1'b1;
                idx  = IW'(i);
                best = prio[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/irq_sp_bank.sv
// Module: holds the main and process stack pointers.
// Presents the pointer chosen by sel_psp and updates one pointer on commit.
module irq_sp_bank #(
    parameter int            AW      = 32,
    parameter logic [AW-1:0] MSP_RST = '0,
    parameter logic [AW-1:0] PSP_RST = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_psp,
    input  logic          commit,
    input  logic          commit_psp,
    input  logic [AW-1:0] commit_val,
    output logic [AW-1:0] sel_sp,
    output logic [AW-1:0] msp,
    output logic [AW-1:0] psp
);
    // Current pointer seen by the sequencer.
    assign sel_sp = sel_psp ? psp : msp;

    // Pointer registers, written only when an entry commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msp <= MSP_RST;
            psp <= PSP_RST;
        end else if (commit) begin
            if (commit_psp) psp <= commit_val;
            else            msp <= commit_val;
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Module: interrupt entry sequencer (top).
// Accepts the most urgent request that beats the running priority, pushes an
// eight-word frame, fetches the vector and enters handler mode in a fixed
// ENTRY_LEN cycles. Assumes writes never stall and vector reads return the
// cycle after vec_re.
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int            N_IRQ    = 8,
    parameter int            PW       = 8,
    parameter int            AW       = 32,
    parameter logic [AW-1:0] VEC_BASE = 32'h0000_0400,
    parameter logic [AW-1:0] MSP_RST  = 32'h2000_8000,
    parameter logic [AW-1:0] PSP_RST  = 32'h2000_4000,
    localparam int           IW       = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_IRQ-1:0]              irq_req,
    input  logic [N_IRQ*PW-1:0]           irq_prio,
    input  logic                          thread_psp,
    input  logic [FRAME_WORDS*WORD_W-1:0] frame_in,
    output logic                          mem_we,
    output logic [AW-1:0]                 mem_addr,
    output logic [WORD_W-1:0]             mem_wdata,
    output logic                          vec_re,
    output logic [AW-1:0]                 vec_addr,
    input  logic [WORD_W-1:0]             vec_rdata,
    output logic                          done,
    output logic [LAT_W-1:0]              entry_lat,
    output logic                          handler_mode,
    output logic [IW-1:0]                 active_line,
    output logic [PW:0]                   run_prio,
    output logic [AW-1:0]                 msp_out,
    output logic [AW-1:0]                 psp_out,
    output logic [WORD_W-1:0]             pc_out,
    output logic [WORD_W-1:0]             lr_out
);
    localparam int SW        = $clog2(ENTRY_LEN + 1);
    localparam int FW        = $clog2(FRAME_WORDS);
    localparam int VEC_STEP  = FRAME_WORDS;
    localparam int CAP_STEP  = FRAME_WORDS + 1;
    localparam int LAST_STEP = ENTRY_LEN - 1;

    seq_state_t        state_q;
    logic [SW-1:0]     step_q;
    logic [IW-1:0]     line_q;
    logic [AW-1:0]     base_q;
    logic              psp_q;
    logic [WORD_W-1:0] ret_q;
    logic [WORD_W-1:0] vec_q;
    logic [WORD_W-1:0] frame_q [FRAME_WORDS];
    logic [LAT_W-1:0]  lat_q;
    logic [N_IRQ-1:0]  pend_q;
    logic [N_IRQ-1:0]  cand;
    logic [N_IRQ-1:0]  take_mask;
    logic              hit;
    logic [IW-1:0]     pick_idx;
    logic [PW-1:0]     pick_prio;
    logic              use_psp_now;
    logic              accept;
    logic              busy;
    logic              last_step;
    logic [AW-1:0]     sel_sp;
    logic [FW-1:0]     wsel;

    // Live requests join latched ones so a same-cycle request is judged at once.
    assign cand        = pend_q | irq_req;
    assign use_psp_now = !handler_mode && thread_psp;
    assign busy        = (state_q == SQ_BUSY);
    assign accept      = (state_q == SQ_IDLE) && hit && ({1'b0, pick_prio} < run_prio);
    assign last_step   = busy && (step_q == SW'(LAST_STEP));

    irq_prio_pick #(.N_IRQ(N_IRQ), .PW(PW), .IW(IW)) pick_i (
        .cand (cand),
        .prio (irq_prio),
        .hit  (hit),
        .idx  (pick_idx),
        .best (pick_prio)
    );

    irq_sp_bank #(.AW(AW), .MSP_RST(MSP_RST), .PSP_RST(PSP_RST)) sp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_psp    (use_psp_now),
        .commit     (last_step),
        .commit_psp (psp_q),
        .commit_val (base_q - AW'(FRAME_WORDS * 4)),
        .sel_sp     (sel_sp),
        .msp        (msp_out),
        .psp        (psp_out)
    );

    // One-hot clear mask for the accepted line.
    always_comb begin
        take_mask = '0;
        if (accept) take_mask[pick_idx] = 1'b1;
    end

    // Pending latch: collect requests, drop the accepted one.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= cand & ~take_mask;
    end

    // Sequencer: capture context on accept, then step through the fixed schedule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_IDLE;
            step_q   <= '0;
            line_q   <= '0;
            base_q   <= '0;
            psp_q    <= 1'b0;
            ret_q    <= '0;
            vec_q    <= '0;
            lat_q    <= '0;
            run_prio <= {1'b1, {PW{1'b0}}};
            for (int k = 0; k < FRAME_WORDS; k++) frame_q[k] <= '0;
        end else if (accept) begin
            state_q  <= SQ_BUSY;
            step_q   <= '0;
            line_q   <= pick_idx;
            base_q   <= sel_sp;
            psp_q    <= use_psp_now;
            ret_q    <= ret_code(handler_mode, use_psp_now);
            lat_q    <= LAT_W'(1);
            run_prio <= {1'b0, pick_prio};
            for (int k = 0; k < FRAME_WORDS; k++) frame_q[k] <= frame_in[k*WORD_W +: WORD_W];
        end else if (busy) begin
            step_q <= step_q + SW'(1);
            lat_q  <= lat_q + LAT_W'(1);
            if (step_q == SW'(CAP_STEP)) vec_q <= vec_rdata;
            if (last_step) state_q <= SQ_IDLE;
        end
    end

    // Commit: publish the handler context and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            handler_mode <= 1'b0;
            active_line  <= '0;
            pc_out       <= '0;
            lr_out       <= '0;
            done         <= 1'b0;
            entry_lat    <= '0;
        end else begin
            done <= last_step;
            if (last_step) begin
                handler_mode <= 1'b1;
                active_line  <= line_q;
                pc_out       <= {vec_q[WORD_W-1:1], 1'b0};
                lr_out       <= ret_q;
                entry_lat    <= lat_q;
            end
        end
    end

    // Memory and vector port drive, decoded from the step count.
    assign wsel      = FW'(FRAME_WORDS - 1) - step_q[FW-1:0];
    assign mem_we    = busy && (step_q < SW'(FRAME_WORDS));
    assign mem_addr  = base_q - (AW'(step_q + SW'(1)) << 2);
    assign mem_wdata = frame_q[wsel];
    assign vec_re    = busy && (step_q == SW'(VEC_STEP));
    assign vec_addr  = VEC_BASE + ((AW'(EXC_OFS) + AW'(line_q)) << 2);
endmodule

// File: rtl/irq_entry_seq_chk.sv
// Module: property checker for irq_entry_seq, attached by bind.
// Observes ports only; counts frame writes between completions.
module irq_entry_seq_chk
    import irq_entry_pkg::*;
#(
    parameter int AW = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_we,
    input logic [AW-1:0]    mem_addr,
    input logic             vec_re,
    input logic             done,
    input logic [LAT_W-1:0] entry_lat,
    input logic             handler_mode,
    input logic [AW-1:0]    msp_out,
    input logic [AW-1:0]    psp_out
);
    logic [7:0] wr_cnt;

    // Writes seen since the last completion.
    always_ff @(posedge clk) begin
        if (!rst_n)    wr_cnt <= '0;
        else if (done) wr_cnt <= {7'd0, mem_we};
        else           wr_cnt <= wr_cnt + {7'd0, mem_we};
    end

    a_r4_eight_words: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> wr_cnt == 8'(FRAME_WORDS));
    a_r4_descending: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) - AW'(4));
    a_r6_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && vec_re));
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_fixed_lat: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> entry_lat == LAT_W'(ENTRY_LEN));
    a_r8_handler: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> handler_mode);
    a_r5_msp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(msp_out));
    a_r5_psp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(psp_out));
    a_r5_one_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($stable(msp_out) || $stable(psp_out)));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.AW(AW)) chk_i (.*);

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;
    localparam int          N   = 8;
    localparam int          PW  = 8;
    localparam int          AW  = 32;
    localparam logic [31:0] VB  = 32'h0000_0400;
    localparam logic [31:0] MR  = 32'h2000_8000;
    localparam logic [31:0] PR  = 32'h2000_4000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic [N*PW-1:0] irq_prio = '1;
    logic          thread_psp = 1'b0;
    logic [255:0]  frame_in = '0;
    logic          mem_we;
    logic [31:0]   mem_addr, mem_wdata;
    logic          vec_re;
    logic [31:0]   vec_addr;
    logic [31:0]   vec_rdata = '0;
    logic          done;
    logic [7:0]    entry_lat;
    logic          handler_mode;
    logic [2:0]    active_line;
    logic [8:0]    run_prio;
    logic [31:0]   msp_out, psp_out, pc_out, lr_out;

    int checks = 0, errors = 0;
    int cyc = 0, done_count = 0, total_wr = 0, wr_n = 0, first_cyc = 0;
    int last_n = 0, last_gap = 0;
    logic [31:0] cur_a [8], cur_d [8], last_a [8], last_d [8];
    logic [31:0] cur_vec = '0, last_vec = '0;
    logic [31:0] exp_msp, exp_psp;
    logic        exp_hnd;

    irq_entry_seq #(.N_IRQ(N), .PW(PW), .AW(AW), .VEC_BASE(VB), .MSP_RST(MR), .PSP_RST(PR)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_prio(irq_prio),
        .thread_psp(thread_psp), .frame_in(frame_in),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .vec_re(vec_re), .vec_addr(vec_addr), .vec_rdata(vec_rdata),
        .done(done), .entry_lat(entry_lat), .handler_mode(handler_mode),
        .active_line(active_line), .run_prio(run_prio),
        .msp_out(msp_out), .psp_out(psp_out), .pc_out(pc_out), .lr_out(lr_out)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] vec_val(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, a[15:0]} | 32'h1;
    endfunction

    function automatic int pick(input logic [N-1:0] m);
        int w = -1;
        for (int i = 0; i < N; i++)
            if (m[i] && (w < 0 || irq_prio[i*PW +: PW] < irq_prio[w*PW +: PW])) w = i;
        return w;
    endfunction

    // Port monitor: records frame writes, serves vector reads, snapshots at done.
    always @(negedge clk) begin
        if (!rst_n) wr_n = 0;
        else begin
            if (mem_we) begin
                if (wr_n < 8) begin cur_a[wr_n] = mem_addr; cur_d[wr_n] = mem_wdata; end
                if (wr_n == 0) first_cyc = cyc;
                wr_n++; total_wr++;
            end
            if (vec_re) begin cur_vec = vec_addr; vec_rdata = vec_val(vec_addr); end
            if (done) begin
                last_n = wr_n; last_vec = cur_vec; last_gap = cyc - first_cyc;
                for (int k = 0; k < 8; k++) begin last_a[k] = cur_a[k]; last_d[k] = cur_d[k]; end
                wr_n = 0; done_count++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; irq_req = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_msp = MR; exp_psp = PR; exp_hnd = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        @(negedge clk); irq_req = m;
        @(negedge clk); irq_req = '0;
    endtask

    task automatic wait_done();
        int start = done_count;
        int guard = 0;
        while (done_count == start && guard < 200) begin @(posedge clk); guard++; end
        #1;
        chk(done_count != start, "R9 done seen", 32'(done_count), 32'(start + 1));
    endtask

    task automatic rand_frame();
        for (int k = 0; k < 8; k++) frame_in[k*32 +: 32] = $urandom;
    endtask

    // Compare the recorded entry against the bench model, then advance the model.
    task automatic check_entry(input int line);
        logic        up;
        logic [31:0] base, ret, va;
        int          bad;
        up   = !exp_hnd && thread_psp;
        base = up ? exp_psp : exp_msp;
        ret  = exp_hnd ? 32'hFFFF_FFF1 : (up ? 32'hFFFF_FFFD : 32'hFFFF_FFF9);
        va   = VB + 32'(4 * (16 + line));
        bad  = -1;
        for (int k = 0; k < 8; k++)
            if (last_a[k] != base - 32'(4 * (k + 1)) || last_d[k] != frame_in[(7-k)*32 +: 32]) if (bad < 0) bad = k;
        chk(last_n == 8, "R4 write count", 32'(last_n), 32'd8);
        chk(bad < 0, "R4 frame layout", (bad < 0) ? 32'd0 : last_a[bad], (bad < 0) ? 32'd0 : base - 32'(4 * (bad + 1)));
        chk(last_vec == va, "R6 vector address", last_vec, va);
        chk(pc_out == (vec_val(va) & ~32'h1), "R6 handler pc", pc_out, vec_val(va) & ~32'h1);
        chk(lr_out == ret, "R7 return code", lr_out, ret);
        if (up) exp_psp = exp_psp - 32; else exp_msp = exp_msp - 32;
        chk(msp_out == exp_msp, "R5 main pointer", msp_out, exp_msp);
        chk(psp_out == exp_psp, "R5 process pointer", psp_out, exp_psp);
        chk(handler_mode == 1'b1, "R8 handler mode", 32'(handler_mode), 32'd1);
        chk(32'(active_line) == 32'(line), "R2 accepted line", 32'(active_line), 32'(line));
        chk(last_gap == 12 && entry_lat == 8'd12, "R9 fixed latency", 32'(last_gap), 32'd12);
        exp_hnd = 1'b1;
    endtask

    task automatic expect_idle(input string req);
        int d0 = done_count, w0 = total_wr;
        repeat (40) @(negedge clk);
        chk(done_count == d0 && total_wr == w0, req, 32'(total_wr - w0), 32'd0);
    endtask

    initial begin
        int r = $urandom(32'd20240611);
        if (r == 0) r = 1;
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk(handler_mode == 1'b0, "R1 thread mode", 32'(handler_mode), 32'd0);
        chk(msp_out == MR, "R1 main pointer", msp_out, MR);
        chk(psp_out == PR, "R1 process pointer", psp_out, PR);
        chk(run_prio == 9'd256, "R1 idle priority", 32'(run_prio), 32'd256);
        chk(!mem_we && !vec_re && !done, "R1 quiet ports", {29'd0, mem_we, vec_re, done}, 32'd0);

        // Thread on process stack, then nested entry (R5, R7)
        thread_psp = 1'b1; rand_frame();
        irq_prio[3*PW +: PW] = 8'h80; irq_prio[6*PW +: PW] = 8'h40;
        irq_prio[1*PW +: PW] = 8'h40; irq_prio[5*PW +: PW] = 8'h90;
        pulse(8'h08); wait_done(); check_entry(3);
        chk(run_prio == 9'h080, "R8 running priority", 32'(run_prio), 32'h80);
        rand_frame();
        pulse(8'h40); wait_done(); check_entry(6);   // R5: thread_psp ignored in handler mode
        // R3 equal and lower urgency stay pending
        pulse(8'h02); expect_idle("R3 equal priority not taken");
        pulse(8'h20); expect_idle("R3 lower priority not taken");

        // R2 tie goes to lower index; the loser then blocks on equal priority
        do_reset(); thread_psp = 1'b0; rand_frame();
        irq_prio = '1; irq_prio[2*PW +: PW] = 8'h10; irq_prio[4*PW +: PW] = 8'h10;
        pulse(8'h14); wait_done(); check_entry(2);
        expect_idle("R3 tied loser stays pending");

        // R11 request arriving mid-entry is taken afterwards
        do_reset(); rand_frame();
        irq_prio = '1; irq_prio[2*PW +: PW] = 8'h50; irq_prio[5*PW +: PW] = 8'h20;
        pulse(8'h04); repeat (4) @(negedge clk); pulse(8'h20);
        wait_done(); check_entry(2);
        wait_done(); check_entry(5);   // R11

        // R10 request in the done cycle starts the next frame at once
        do_reset(); rand_frame();
        irq_prio = '1; irq_prio[0] = 1'b0; irq_prio[0 +: PW] = 8'h30; irq_prio[7*PW +: PW] = 8'h20;
        pulse(8'h01);
        begin
            int g = 0;
            @(negedge clk);
            while (!done && g < 100) begin @(negedge clk); g++; end
            irq_req = 8'h80;
            @(negedge clk); irq_req = '0;
            chk(mem_we == 1'b1, "R10 back-to-back entry", 32'(mem_we), 32'd1);
        end
        check_entry(0);
        wait_done(); check_entry(7);

        // Random contests with a nested follow-up
        for (int t = 0; t < 20; t++) begin
            int a, b, c, w;
            logic [7:0] wp;
            do_reset();
            thread_psp = 1'($urandom % 2);
            for (int i = 0; i < N; i++) irq_prio[i*PW +: PW] = 8'($urandom);
            rand_frame();
            a = $urandom % N;
            b = (a + 1 + ($urandom % (N - 1))) % N;
            w = pick(N'(1 << a) | N'(1 << b));
            wp = irq_prio[w*PW +: PW];
            pulse(N'(1 << a) | N'(1 << b));
            wait_done(); check_entry(w);   // R2 random contest
            if (wp != 8'd0) begin
                c = (b + 1) % N;
                if (c == a) c = (c + 1) % N;
                irq_prio[c*PW +: PW] = 8'($urandom % wp);
                rand_frame();
                pulse(N'(1 << c));
                wait_done(); check_entry(c);   // R7 nested from handler
            end
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule